// File: doc/BRIEF.md
# Byte-Addressed Memory with Atomic Swap and Compare-and-Swap

This block is a synchronous, byte-addressed memory behind one request port. Each cycle it can take one request: a read, a write, an invalidate acknowledge, an unconditional swap or a compare-and-swap. Access sizes are 1, 2, 4 or 8 bytes and must fall inside a window that starts at `BASE_ADDR` and spans `NUM_PAGES` pages of `PAGE_BYTES` bytes each. Because the size is built from whole pages, it is always a multiple of the page size.

The memory is read and updated in the cycle it accepts a request. The response then travels through a fixed pipeline of `LATENCY` stages. Every request gets exactly one response, in issue order, after the same number of cycles whatever its kind or size. The atomic commands return the contents that were stored before the command. A compare-and-swap writes only when those contents equal a separate compare operand. When `CLEAR_ON_RESET` is set, reset zeroes the whole array.

Top module: `atomic_mem`

## Requirements
- R1: While reset is held and right after it, `rsp_valid` is low. With `CLEAR_ON_RESET`=1, every byte reads as zero after reset.
- R2: A read (op 0) returns the addressed bytes, little-endian and zero-extended. Byte lanes come from address bits [2:0]. Size code s selects 2^s bytes.
- R3: A write (op 1) changes only the addressed bytes and returns zero data. No byte changes in a cycle without a request.
- R4: A swap (op 3) returns the prior contents and always stores the request data.
- R5: A compare-and-swap (op 4) returns the prior contents. It stores the request data only when the prior contents equal `req_cmp`. At 4 bytes, only `req_cmp[31:0]` takes part in the compare.
- R6: A compare-and-swap with size code 0 or 1 gives an error response and stores nothing.
- R7: An access whose address is not a multiple of its size gives an error response and stores nothing.
- R8: An access that is not wholly inside [BASE_ADDR, BASE_ADDR + NUM_PAGES*PAGE_BYTES) gives an error response and stores nothing.
- R9: An error response always carries zero data.
- R10: An invalidate (op 2) is acknowledged without error and with zero data, at any address, and changes no memory.
- R11: A request driven before clock edge k has its response valid after edge k+LATENCY-1. One request can be taken per cycle, and responses come out in order.
- R12: Op codes 5 to 7 give an error response and store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | 0 read, 1 write, 2 invalidate, 3 swap, 4 compare-and-swap |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of the access size in bytes |
| req_wdata | input | 64 | Write or swap data, right-aligned |
| req_cmp | input | 64 | Compare operand for compare-and-swap, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | The request was illegal and had no effect |
| rsp_rdata | output | 64 | Read or prior data, right-aligned, zero-extended |

## Verification
The assertions assume that the request fields are valid whenever `req_valid` is high, and that `req_op` and `req_size` never carry X. They also assume a legal parameter set: `BASE_ADDR` and `PAGE_BYTES` are multiples of eight. The stimulus changes inputs only at falling edges and drives every field on every request, so each sampled request is fully defined. Back-to-back bursts mix legal accesses with misaligned, out-of-window, undersized compare and unknown-op requests. The outstanding-request bound is therefore exercised at full pipeline occupancy, and the no-store properties are exercised on requests that really are illegal.

// File: rtl/atomic_mem_pkg.sv
package atomic_mem_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_INVAL = 3'd2,
    OP_SWAP  = 3'd3,
    OP_CAS   = 3'd4
  } mem_op_e;

  localparam int WORD_W = 64;
endpackage

// File: rtl/atomic_mem_exec.sv
module atomic_mem_exec
  import atomic_mem_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int                MEM_BYTES = 256,
  parameter int                IDX_W     = 5
) (
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] cmp,
  input  logic [WORD_W-1:0] old_word,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word,
  output logic              err,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [ADDR_W:0] BASE_X  = {1'b0, BASE_ADDR};
  localparam logic [ADDR_W:0] LIMIT_X = BASE_X + (ADDR_W+1)'(MEM_BYTES);

  logic [ADDR_W:0]   addr_x, offset;
  logic              in_range, aligned, cond_ok, known_op, reads_old;
  logic [2:0]        align_mask;
  logic [5:0]        shamt;
  logic [WORD_W-1:0] fmask, old_field, lane_mask;
  logic              unused_offset;

  assign addr_x        = {1'b0, addr};
  assign offset        = addr_x - BASE_X;
  assign in_range      = (addr_x >= BASE_X) && (addr_x < LIMIT_X);
  assign idx           = offset[IDX_W+2:3];
  assign unused_offset = ^{offset[ADDR_W:IDX_W+3], offset[2:0]};
  assign shamt         = {addr[2:0], 3'b000};

  always_comb begin
    case (size)
      2'd0:    begin fmask = 64'h0000_0000_0000_00ff; align_mask = 3'b000; end
      2'd1:    begin fmask = 64'h0000_0000_0000_ffff; align_mask = 3'b001; end
      2'd2:    begin fmask = 64'h0000_0000_ffff_ffff; align_mask = 3'b011; end
      default: begin fmask = '1;                      align_mask = 3'b111; end
    endcase
  end

  assign aligned   = (addr[2:0] & align_mask) == 3'b000;
  assign old_field = (old_word >> shamt) & fmask;
  assign lane_mask = fmask << shamt;
  assign cond_ok   = (size == 2'd3) ? (old_field == cmp)
                                    : (old_field[31:0] == cmp[31:0]);
  assign wr_word   = (old_word & ~lane_mask) | ((wdata & fmask) << shamt);

  always_comb begin
    known_op  = 1'b1;
    reads_old = 1'b0;
    wr_en     = 1'b0;
    err       = 1'b0;
    case (op)
      OP_READ:  reads_old = 1'b1;
      OP_WRITE: wr_en = 1'b1;
      OP_INVAL: ;
      OP_SWAP:  begin reads_old = 1'b1; wr_en = 1'b1; end
      OP_CAS:   begin
        reads_old = 1'b1;
        wr_en     = cond_ok;
        if (!size[1]) err = 1'b1;
      end
      default:  known_op = 1'b0;
    endcase
    if (!known_op) err = 1'b1;
    if (op != OP_INVAL && (!in_range || !aligned)) err = 1'b1;
    if (err) begin
      wr_en     = 1'b0;
      reads_old = 1'b0;
    end
  end

  assign rdata = reads_old ? old_field : '0;
endmodule

// File: rtl/atomic_mem_store.sv
module atomic_mem_store
  import atomic_mem_pkg::*;
#(
  parameter int DEPTH          = 32,
  parameter int IDX_W          = 5,
  parameter bit CLEAR_ON_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] rd_word,
  input  logic              we,
  input  logic [WORD_W-1:0] wr_word
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  generate
    if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
          mem_q[idx] <= wr_word;
        end
      end
    end else begin : g_noclear
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
        if (we) mem_q[idx] <= wr_word;
      end
    end
  endgenerate

  assign rd_word = mem_q[idx];
endmodule

// File: rtl/atomic_mem_pipe.sv
module atomic_mem_pipe
  import atomic_mem_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_err,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_err,
  output logic [WORD_W-1:0] out_data
);
  for (genvar s = 0; s < LATENCY; s++) begin : g_stage
    logic              v_d, e_d, v_q, e_q;
    logic [WORD_W-1:0] d_d, d_q;

    if (s == 0) begin : g_head
      assign v_d = in_valid;
      assign e_d = in_err;
      assign d_d = in_data;
    end else begin : g_link
      assign v_d = g_stage[s-1].v_q;
      assign e_d = g_stage[s-1].e_q;
      assign d_d = g_stage[s-1].d_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (v_d) begin
        e_q <= e_d;
        d_q <= d_d;
      end
    end
  end

  assign out_valid = g_stage[LATENCY-1].v_q;
  assign out_err   = g_stage[LATENCY-1].e_q;
  assign out_data  = g_stage[LATENCY-1].d_q;
endmodule

// File: rtl/atomic_mem.sv
module atomic_mem
  import atomic_mem_pkg::*;
#(
  parameter int                ADDR_W         = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR      = 16'h1000,
  parameter int                PAGE_BYTES     = 64,
  parameter int                NUM_PAGES      = 4,
  parameter int                LATENCY        = 3,
  parameter bit                CLEAR_ON_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic [63:0]       req_cmp,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata
);
  localparam int MEM_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam int DEPTH     = MEM_BYTES / 8;
  localparam int IDX_W     = $clog2(DEPTH);

  logic [IDX_W-1:0]  word_idx;
  logic [WORD_W-1:0] old_word, new_word, exec_rdata;
  logic              exec_we, exec_err, store_we;

  atomic_mem_exec #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MEM_BYTES(MEM_BYTES), .IDX_W(IDX_W)
  ) u_exec (
    .op(req_op), .addr(req_addr), .size(req_size), .wdata(req_wdata), .cmp(req_cmp),
    .old_word(old_word), .idx(word_idx), .wr_en(exec_we), .wr_word(new_word),
    .err(exec_err), .rdata(exec_rdata)
  );

  assign store_we = req_valid & exec_we;

  atomic_mem_store #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .idx(word_idx), .rd_word(old_word),
    .we(store_we), .wr_word(new_word)
  );

  atomic_mem_pipe #(.LATENCY(LATENCY)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_err(exec_err), .in_data(exec_rdata),
    .out_valid(rsp_valid), .out_err(rsp_err), .out_data(rsp_rdata)
  );
endmodule

// File: rtl/atomic_mem_chk.sv
module atomic_mem_chk #(
  parameter int LATENCY = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_op,
  input logic        req_addr_lsb,
  input logic [1:0]  req_size,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] rsp_rdata,
  input logic        store_we,
  input logic        exec_err
);
  localparam int CW = $clog2(LATENCY + 2);

  logic [CW-1:0] open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= '0;
    else        open_q <= open_q + CW'(req_valid) - CW'(rsp_valid);
  end

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 64'd0)); // R9
  AST_INVAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2) |-> !store_we); // R10
  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr_lsb && req_size != 2'd0) |-> !store_we); // R7
  AST_CAS_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4 && !req_size[1]) |-> (exec_err && !store_we)); // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !store_we); // R3
  AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (open_q != '0)); // R11
  AST_OPEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    open_q <= CW'(LATENCY)); // R11
endmodule

bind atomic_mem atomic_mem_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr_lsb(req_addr[0]), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .store_we(store_we), .exec_err(exec_err)
);

// File: tb/atomic_mem_bench.sv
module atomic_mem_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 16;
  localparam logic [15:0] BASE       = 16'h1000;
  localparam int          PAGE_BYTES = 64;
  localparam int          NUM_PAGES  = 4;
  localparam int          MEM        = PAGE_BYTES * NUM_PAGES;
  localparam int          LAT        = 3;

  logic        clk, rst_n, req_valid;
  logic [2:0]  req_op;
  logic [15:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_wdata, req_cmp;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  atomic_mem #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE), .PAGE_BYTES(PAGE_BYTES),
    .NUM_PAGES(NUM_PAGES), .LATENCY(LAT), .CLEAR_ON_RESET(1'b1)
  ) u_atomic_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_cmp(req_cmp), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  typedef struct {
    string       tag;
    logic        err;
    logic [63:0] data;
    int          cyc;
  } exp_t;

  exp_t        sb[$];
  exp_t        got;
  byte unsigned model [MEM];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic issue(string tag, int op, int addr, int size,
                       logic [63:0] wd, logic [63:0] cv);
    int nb, off;
    bit inr, al, e, wr;
    logic [63:0] old, rd;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = 3'(op);
    req_addr  = 16'(addr);
    req_size  = 2'(size);
    req_wdata = wd;
    req_cmp   = cv;
    nb  = 1 << size;
    off = addr - int'(BASE);
    inr = (addr >= int'(BASE)) && (off + nb <= MEM);
    al  = (addr % nb) == 0;
    old = '0;
    if (inr) for (int b = 0; b < nb; b++) old[8*b +: 8] = model[off+b];
    e = 0; wr = 0; rd = '0;
    if (op > 4) e = 1;
    if (op == 4 && size < 2) e = 1;
    if (op != 2 && (!inr || !al)) e = 1;
    if (!e) begin
      case (op)
        0: rd = old;
        1: wr = 1;
        3: begin rd = old; wr = 1; end
        4: begin
          rd = old;
          wr = (size == 3) ? (old == cv) : (old[31:0] == cv[31:0]);
        end
        default: ;
      endcase
    end
    if (wr) for (int b = 0; b < nb; b++) model[off+b] = wd[8*b +: 8];
    sb.push_back('{tag, e, rd, cyc + LAT});
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid && !finished) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected response: err=%0b data=%h expected none",
                 rsp_err, rsp_rdata);
      end else begin
        got = sb.pop_front();
        if (rsp_err !== got.err || rsp_rdata !== got.data || cyc != got.cyc) begin
          n_fail++;
          $display("FAIL %s: err=%0b data=%h cyc=%0d expected err=%0b data=%h cyc=%0d",
                   got.tag, rsp_err, rsp_rdata, cyc, got.err, got.data, got.cyc);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog expired: pending=%0d expected 0", sb.size());
    summary();
  end

  initial begin
    for (int i = 0; i < MEM; i++) model[i] = 8'h00;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
    req_size = '0; req_wdata = '0; req_cmp = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 rsp_valid in reset: %b expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 rsp_valid after reset: %b expected 0", rsp_valid);
    end

    // R1 cleared contents
    issue("R1", 0, BASE, 3, 0, 0);
    issue("R1", 0, BASE + MEM - 8, 3, 0, 0);
    idle(2);

    // R2 / R3 little-endian lanes and partial writes
    issue("R3", 1, BASE, 3, 64'h1122_3344_5566_7788, 0);
    issue("R2", 0, BASE, 3, 0, 0);
    issue("R2", 0, BASE + 1, 0, 0, 0);
    issue("R2", 0, BASE + 6, 1, 0, 0);
    issue("R3", 1, BASE + 3, 0, 64'hffff_ffff_ffff_ffab, 0);
    issue("R3", 0, BASE, 2, 0, 0);
    issue("R3", 1, BASE + 12, 2, 64'hdead_beef, 0);
    issue("R2", 0, BASE + 8, 3, 0, 0);
    idle(4);

    // R4 swap
    issue("R4", 3, BASE + 4, 2, 64'h0bad_cafe, 0);
    issue("R4", 0, BASE, 3, 0, 0);
    issue("R4", 3, BASE + 16, 3, 64'h0123_4567_89ab_cdef, 0);
    issue("R4", 0, BASE + 16, 3, 0, 0);
    idle(2);

    // R5 compare-and-swap
    issue("R5", 4, BASE + 16, 3, 64'haaaa_bbbb_cccc_dddd, 64'h0123_4567_89ab_cdef);
    issue("R5", 4, BASE + 16, 3, 64'h5555_5555_5555_5555, 64'h0123_4567_89ab_cdef);
    issue("R5", 0, BASE + 16, 3, 0, 0);
    issue("R5", 4, BASE + 12, 2, 64'h1234_5678, 64'hffff_0000_dead_beef);
    issue("R5", 4, BASE + 8, 2, 64'h9999_9999, 64'h1);
    issue("R5", 0, BASE + 8, 3, 0, 0);
    idle(2);

    // R6 undersized compare-and-swap
    issue("R6", 4, BASE + 8, 0, 64'h11, 64'h0);
    issue("R6", 4, BASE + 8, 1, 64'h1111, 64'h0);
    issue("R6", 0, BASE + 8, 3, 0, 0);

    // R7 misaligned
    issue("R7", 1, BASE + 2, 2, 64'hffff_ffff, 0);
    issue("R7", 3, BASE + 1, 1, 64'hffff, 0);
    issue("R7", 0, BASE + 4, 3, 0, 0);
    issue("R7", 0, BASE, 3, 0, 0);

    // R8 window edges
    issue("R8", 1, BASE - 8, 3, 64'h77, 0);
    issue("R8", 0, BASE + MEM, 0, 0, 0);
    issue("R8", 1, BASE + MEM - 8, 3, 64'hfeed_face_0000_1111, 0);
    issue("R8", 0, BASE + MEM - 1, 0, 0, 0);
    idle(2);

    // R10 invalidate, R12 unknown op, R9 zero data on error
    issue("R10", 2, BASE + 16, 3, 64'hffff, 0);
    issue("R10", 2, 16'h0004, 3, 64'hffff, 0);
    issue("R10", 0, BASE + 16, 3, 0, 0);
    issue("R12", 5, BASE + 16, 3, 64'h1, 0);
    issue("R12", 7, BASE, 0, 64'h1, 0);
    issue("R9", 0, BASE + 17, 3, 0, 0);
    issue("R12", 0, BASE, 3, 0, 0);
    idle(2);

    // R11 long back-to-back burst
    for (int k = 0; k < 16; k++)
      issue("R11", (k % 2) ? 0 : 3, BASE + 32 + 8 * (k / 2), 3, 64'(k * 64'h0101_0101), 0);
    idle(LAT + 4);

    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R11 responses missing: %0d expected 0", sb.size());
    end
    summary();
  end
endmodule